// File: doc/BRIEF.md
# NMI Acknowledge Watchdog

This block guards a subsystem against non-maskable interrupts that software never services. It watches a vector of NMI flag bits together with a matching vector of enables. While no enabled flag is set the block sits idle. The moment any enabled flag becomes set, a counter starts. Software acknowledges the interrupt by clearing every enabled pending flag. If it does so before the counter reaches the programmed period, the counter returns to zero and nothing else happens.

If the period runs out first, the block issues a one-cycle reset pulse to its own subsystem only. In the same cycle it raises a one-cycle NMI request toward the partner subsystem. It also sets a sticky cause bit that the partner can read and later clear.

The period comes from a 16-bit register written through a plain write strobe. The flag and enable inputs are level signals sampled on every clock edge. All pins are plain control and status signals, so there is no stream interface and no back-pressure.

Top module: `nmi_ack_wdog`

## Requirements
- R1: After reset, `sub_rst`, `partner_nmi` and `wd_cause` are 0, and `period_q` reads 0xFFFF.
- R2: A cycle with `period_wr` high loads `period_wdata`, and it is visible on `period_q` from the next cycle on.
- R3: While no flag bit is set together with its enable bit, no reset pulse is ever issued.
- R4: Counting starts at the first clock edge that samples an enabled pending flag. With period P ≥ 1 held pending, `sub_rst` is high in the cycle after the (P+1)-th consecutive pending edge. A period of 0 behaves like a period of 1.
- R5: If the enabled pending flags are all clear at any sampled edge up to and including the expiry edge, no pulse is issued and the counter returns to zero. A later pending flag then gets the full period again.
- R6: New enabled flags that arrive while counting is under way do not restart the count.
- R7: Flags whose enable bit is 0 neither start the counter nor keep it running.
- R8: `sub_rst` is a one-cycle pulse, and the counter clears when the pulse is issued. While a flag stays pending, pulses therefore repeat every P+1 cycles.
- R9: `partner_nmi` is a one-cycle pulse that is high in exactly the cycles where `sub_rst` is high.
- R10: `wd_cause` is set by every expiry and stays set until `cause_clr`. When an expiry and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_flag | input | NFLAG | NMI pending flags |
| nmi_en | input | NFLAG | Per-flag enables |
| period_wr | input | 1 | Period register write strobe |
| period_wdata | input | PW | Period write value |
| cause_clr | input | 1 | Clears the sticky cause bit |
| period_q | output | PW | Current period value |
| sub_rst | output | 1 | Own-subsystem reset pulse |
| partner_nmi | output | 1 | NMI request pulse to the partner |
| wd_cause | output | 1 | Sticky watchdog-reset cause |

## Verification
A counter that is off by one shifts the reset pulse by one cycle away from P+1 edges after the first pending sample. A counter that fails to clear on acknowledge shortens the next timeout. Both show up at the very next expiry. A state machine stuck in the running state produces a pulse even though flags were cleared, and a restart on new flags delays the pulse past its expected cycle. Cause or notify logic that does not track the timer shows up within the cycle of the pulse, either as `partner_nmi` out of step with `sub_rst` or as `wd_cause` low afterwards.

// File: rtl/nmi_wd_pkg.sv
package nmi_wd_pkg;
  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;
endpackage

// File: rtl/nmi_wd_pend.sv
module nmi_wd_pend #(
  parameter int NFLAG = 8
) (
  input  logic [NFLAG-1:0] flag,
  input  logic [NFLAG-1:0] en,
  output logic             pend
);
  logic [NFLAG-1:0] masked;
  for (genvar i = 0; i < NFLAG; i++) begin : g_mask
    assign masked[i] = flag[i] & en[i];
  end
  assign pend = |masked;
endmodule

// File: rtl/nmi_wd_period.sv
module nmi_wd_period #(
  parameter int              PW      = 16,
  parameter logic [PW-1:0]   RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] period
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  period <= RST_VAL;
    else if (wr) period <= wdata;
  end
endmodule

// File: rtl/nmi_wd_timer.sv
module nmi_wd_timer
  import nmi_wd_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend,
  input  logic [PW-1:0] period,
  output logic          hit,
  output logic          expire
);
  wd_state_e     state;
  logic [PW-1:0] cnt;

  // Expiry is decided on an edge where the count has reached the period
  // and the flags are still pending.
  assign hit = (state == WD_RUN) && pend && (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WD_IDLE;
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      unique case (state)
        WD_IDLE: if (pend) begin
          state <= WD_RUN;
          cnt   <= PW'(1);
        end
        WD_RUN: begin
          if (!pend) begin
            state <= WD_IDLE;
            cnt   <= '0;
          end else if (hit) begin
            expire <= 1'b1;
            state  <= WD_IDLE;
            cnt    <= '0;
          end else begin
            cnt <= cnt + PW'(1);
          end
        end
        default: state <= WD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nmi_wd_notify.sv
module nmi_wd_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic nmi_out,
  output logic cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_out <= 1'b0;
      cause   <= 1'b0;
    end else begin
      nmi_out <= hit;
      if (hit)      cause <= 1'b1;
      else if (clr) cause <= 1'b0;
    end
  end
endmodule

// File: rtl/nmi_ack_wdog.sv
module nmi_ack_wdog #(
  parameter int            NFLAG   = 8,
  parameter int            PW      = 16,
  parameter logic [PW-1:0] PER_RST = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] nmi_flag,
  input  logic [NFLAG-1:0] nmi_en,
  input  logic             period_wr,
  input  logic [PW-1:0]    period_wdata,
  input  logic             cause_clr,
  output logic [PW-1:0]    period_q,
  output logic             sub_rst,
  output logic             partner_nmi,
  output logic             wd_cause
);
  logic pend;
  logic hit;

  nmi_wd_pend #(.NFLAG(NFLAG)) u_pend (
    .flag(nmi_flag), .en(nmi_en), .pend(pend)
  );

  nmi_wd_period #(.PW(PW), .RST_VAL(PER_RST)) u_period (
    .clk(clk), .rst_n(rst_n), .wr(period_wr), .wdata(period_wdata),
    .period(period_q)
  );

  nmi_wd_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .pend(pend), .period(period_q),
    .hit(hit), .expire(sub_rst)
  );

  nmi_wd_notify u_notify (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(cause_clr),
    .nmi_out(partner_nmi), .cause(wd_cause)
  );
endmodule

// File: rtl/nmi_ack_wdog_chk.sv
module nmi_ack_wdog_chk #(
  parameter int NFLAG = 8,
  parameter int PW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] nmi_flag,
  input logic [NFLAG-1:0] nmi_en,
  input logic             period_wr,
  input logic [PW-1:0]    period_wdata,
  input logic             cause_clr,
  input logic [PW-1:0]    period_q,
  input logic             sub_rst,
  input logic             partner_nmi,
  input logic             wd_cause
);
  assert_period_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> period_q == $past(period_wdata));

  assert_no_rst_unpend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(nmi_flag & nmi_en)) |=> !sub_rst);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst |=> !sub_rst);

  assert_nmi_with_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst == partner_nmi);

  assert_cause_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst |-> wd_cause);

  assert_cause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_cause && !cause_clr) |=> wd_cause);
endmodule

bind nmi_ack_wdog nmi_ack_wdog_chk #(.NFLAG(NFLAG), .PW(PW)) u_chk (.*);

// File: tb/nmi_ack_wdog_test.sv
`timescale 1ns/1ps
module nmi_ack_wdog_test;
  localparam int NF = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] nmi_flag = '0;
  logic [NF-1:0] nmi_en = '0;
  logic          period_wr = 1'b0;
  logic [PW-1:0] period_wdata = '0;
  logic          cause_clr = 1'b0;
  logic [PW-1:0] period_q;
  logic          sub_rst, partner_nmi, wd_cause;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int first_pulse = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  bit          m_run;
  int          m_cnt;
  logic [15:0] m_per;
  bit          m_cause;
  bit          m_rst;

  always #10 clk = ~clk;

  nmi_ack_wdog uut (.*);

  function automatic bit pend_of(logic [NF-1:0] f, logic [NF-1:0] e);
    return |(f & e);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_cnt = 0; m_per = 16'hFFFF; m_cause = 0; m_rst = 0;
  endtask

  task automatic model_step();
    bit p, n;
    p = pend_of(nmi_flag, nmi_en);
    n = 0;
    if (!m_run) begin
      if (p) begin m_run = 1; m_cnt = 1; end
    end else if (!p) begin
      m_run = 0; m_cnt = 0;
    end else if (m_cnt >= int'(m_per)) begin
      n = 1; m_run = 0; m_cnt = 0;
    end else m_cnt++;
    if (n) m_cause = 1;
    else if (cause_clr) m_cause = 0;
    if (period_wr) m_per = period_wdata;
    m_rst = n;
  endtask

  // one clock: model follows inputs, outputs compared away from the edge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk("R4 sub_rst", sub_rst, m_rst);
    chk("R9 partner_nmi", partner_nmi, m_rst);
    chk("R10 wd_cause", wd_cause, m_cause);
    chk("R2 period_q", period_q, m_per);
    if (sub_rst) begin
      pulses++;
      if (first_pulse == 0) first_pulse = cyc;
    end
  endtask

  task automatic run(int n);
    pulses = 0; first_pulse = 0; cyc = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wrp(logic [15:0] v);
    period_wr = 1; period_wdata = v;
    tick();
    period_wr = 0;
  endtask

  task automatic quiet();
    nmi_flag = '0; cause_clr = 1;
    tick(); tick();
    cause_clr = 0;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sub_rst", sub_rst, 0);
    chk("R1 partner_nmi", partner_nmi, 0);
    chk("R1 wd_cause", wd_cause, 0);
    chk("R1 period_q", period_q, 16'hFFFF);
    rst_n = 1;
    tick();

    // R7: disabled flags are ignored
    wrp(16'd3);
    nmi_en = 8'h00; nmi_flag = 8'hFF;
    run(60);
    chk("R7 pulses with enables off", pulses, 0);

    // R3: enabled but no flags
    nmi_en = 8'hFF; nmi_flag = 8'h00;
    run(60);
    chk("R3 pulses with no flags", pulses, 0);

    // R4: exact expiry timing, P=5
    wrp(16'd5);
    nmi_flag = 8'h04;
    run(6);
    chk("R4 first pulse cycle P=5", first_pulse, 6);
    quiet();

    // R4: period 0 behaves like 1
    wrp(16'd0);
    nmi_flag = 8'h01;
    run(2);
    chk("R4 first pulse cycle P=0", first_pulse, 2);
    quiet();

    // R5: acknowledge before expiry, then full period again
    wrp(16'd10);
    nmi_flag = 8'h10;
    run(10);
    nmi_flag = 8'h00;
    tick();
    chk("R5 no pulse after ack", pulses, 0);
    nmi_flag = 8'h10;
    run(11);
    chk("R5 full period after ack", first_pulse, 11);
    quiet();

    // R7: disabled flag does not keep counter running
    nmi_en = 8'h0F; nmi_flag = 8'h31;
    run(4);
    nmi_flag = 8'h30;
    run(20);
    chk("R7 disabled flag holds nothing", pulses, 0);
    nmi_en = 8'hFF;
    quiet();

    // R6: new flag while counting does not restart
    nmi_flag = 8'h01;
    run(5);
    nmi_flag = 8'h03;
    for (int i = 0; i < 6; i++) tick();
    chk("R6 pulse not delayed by new flag", first_pulse, 11);
    quiet();

    // R8: repeated pulses every P+1 while pending
    wrp(16'd4);
    nmi_flag = 8'h80;
    run(15);
    chk("R8 pulse count", pulses, 3);
    chk("R8 first pulse", first_pulse, 5);
    nmi_flag = 8'h00;
    tick();

    // R10: clear, then clear coinciding with expiry
    cause_clr = 1; tick(); cause_clr = 0; tick();
    chk("R10 cause cleared", wd_cause, 0);
    wrp(16'd2);
    nmi_flag = 8'h02;
    tick(); tick();
    cause_clr = 1; tick(); cause_clr = 0;
    chk("R10 set wins over clear", wd_cause, 1);
    quiet();

    // constrained random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(15) == 0) nmi_flag = NF'($urandom);
      if ($urandom_range(63) == 0) nmi_en = NF'($urandom);
      if ($urandom_range(7) == 0)  nmi_flag = '0;
      cause_clr = ($urandom_range(40) == 0);
      period_wr = ($urandom_range(150) == 0);
      period_wdata = 16'($urandom_range(30));
      tick();
    end
    period_wr = 0; cause_clr = 0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule